// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is a small processor-style datapath in which every transfer passes over one shared data bus. Four things can put a value on the bus: an external data port, two general registers and the arithmetic/logic unit. Each of them has its own active-low output enable, and a high enable isolates that source. Two working registers capture operands from the bus and feed the ALU inputs directly. They never drive the bus themselves.

A control word from outside sequences the datapath one bus transfer per clock. A register-to-register operation such as "first general register plus second general register into the first" takes three transfers. The first general register goes onto the bus and into the first working register. The second general register goes onto the bus and into the second working register. Then the ALU function is chosen, the ALU result is enabled onto the bus, and the destination general register loads it. The bus is a priority-free OR of the enabled sources, and a flag reports any cycle in which more than one enable is active.

Top module: `bus_datapath`

## Requirements
- R1: An active-low reset clears all four registers to zero. A general register enabled onto the bus during or right after reset reads as zero.
- R2: When the external enable `ext_oe_n` is low and no other enable is low, the bus equals `ext_data` in the same cycle.
- R3: When all four output enables are high, the bus reads zero.
- R4: A general register loads the bus value on a rising clock edge when its load strobe is high. Otherwise it keeps its value.
- R5: A general register whose output enable is low, with no other enable low, places its stored value on the bus in the same cycle.
- R6: A working register loads the bus value on a rising clock edge when its load strobe is high. Its contents never appear on the bus unless the ALU enable is low.
- R7: The ALU takes A from the first working register and B from the second. It computes, modulo 2^W, by the 3-bit `alu_op` code:
  - 0: A+B+cin
  - 1: A+~B+cin (A−B when cin=1)
  - 2: A AND B
  - 3: A OR B
  - 4: A XOR B
  - 5: NOT A
  - 6: NOT B
  - 7: A
- R8: The ALU result reaches the bus only while `alu_oe_n` is low.
- R9: When more than one enable is low, the bus is the bitwise OR of all enabled sources and `bus_conflict` is 1. With zero or one enable low, `bus_conflict` is 0.
- R10: The three-transfer sequence (GR1→DR1, GR2→DR2, ALU→destination GR) leaves the ALU result of the two general registers in the destination general register. A destination load in the same cycle as the ALU drive captures the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_data | input | W | External data source value |
| ext_oe_n | input | 1 | Active-low bus enable of the external source |
| gr1_oe_n | input | 1 | Active-low bus enable of general register 1 |
| gr2_oe_n | input | 1 | Active-low bus enable of general register 2 |
| alu_oe_n | input | 1 | Active-low bus enable of the ALU result |
| gr1_ld | input | 1 | Load strobe of general register 1 |
| gr2_ld | input | 1 | Load strobe of general register 2 |
| dr1_ld | input | 1 | Load strobe of working register 1 (ALU A) |
| dr2_ld | input | 1 | Load strobe of working register 2 (ALU B) |
| alu_op | input | 3 | ALU function code |
| alu_cin | input | 1 | ALU carry input for the arithmetic codes |
| bus_o | output | W | Current bus value |
| bus_conflict | output | 1 | High when more than one enable is low |

## Verification
The hardest situation to reach is a result written back into a register that is also an operand. Examples are GR1+GR2→GR1, or a load in the same cycle that the ALU drives the bus. Both depend on the working registers holding stale copies while the bus carries the new result. The stimulus runs every ALU code through the full three-transfer sequence, with destinations alternating between the two general registers. Register contents therefore feed back into the operands of later sequences. It also drives deliberate double-enable cycles with a simultaneous load, so the register captures the OR of the sources.

// File: rtl/dp_pkg.sv
package dp_pkg;
   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_NOTA  = 3'd5,
      OP_NOTB  = 3'd6,
      OP_PASSA = 3'd7
   } alu_op_e;

   localparam int unsigned SRC_EXT = 0;
   localparam int unsigned SRC_GR1 = 1;
   localparam int unsigned SRC_GR2 = 2;
   localparam int unsigned SRC_ALU = 3;
   localparam int unsigned N_SRC   = 4;

   localparam int unsigned REG_GR1 = 0;
   localparam int unsigned REG_GR2 = 1;
   localparam int unsigned REG_DR1 = 2;
   localparam int unsigned REG_DR2 = 3;
   localparam int unsigned N_REG   = 4;
endpackage

// File: rtl/dp_ldreg.sv
module dp_ldreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("dp_ldreg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   input  logic         cin,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cin_ext;
   logic [W-1:0] b_sel;
   logic [W-1:0] sum;

   generate
      if (W < 1) begin : g_bad_width
         $error("dp_alu: W must be at least 1");
      end
   endgenerate

   assign cin_ext = cin ? ONE : '0;
   assign b_sel   = (op == OP_SUB) ? ~b : b;
   assign sum     = a + b_sel + cin_ext;

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: y = sum;
         OP_AND:         y = a & b;
         OP_OR:          y = a | b;
         OP_XOR:         y = a ^ b;
         OP_NOTA:        y = ~a;
         OP_NOTB:        y = ~b;
         OP_PASSA:       y = a;
         default:        y = '0;
      endcase
   end
endmodule

// File: rtl/dp_bus.sv
module dp_bus #(
   parameter int unsigned W = 8,
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] oe_n,
   input  logic [W-1:0] src [N],
   output logic [W-1:0] bus,
   output logic         conflict
);
   localparam int unsigned CW = $clog2(N + 1);

   logic [W-1:0] gated [N];
   logic [CW-1:0] active_cnt;

   generate
      if (N < 2) begin : g_bad_count
         $error("dp_bus: N must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("dp_bus: W must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_gate
         assign gated[i] = oe_n[i] ? '0 : src[i];
      end
   endgenerate

   always_comb begin
      bus        = '0;
      active_cnt = '0;
      for (int i = 0; i < N; i++) begin
         bus        = bus | gated[i];
         active_cnt = active_cnt + CW'(!oe_n[i]);
      end
   end

   assign conflict = (active_cnt > CW'(1));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
   import dp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ext_data,
   input  logic         ext_oe_n,
   input  logic         gr1_oe_n,
   input  logic         gr2_oe_n,
   input  logic         alu_oe_n,
   input  logic         gr1_ld,
   input  logic         gr2_ld,
   input  logic         dr1_ld,
   input  logic         dr2_ld,
   input  logic [2:0]   alu_op,
   input  logic         alu_cin,
   output logic [W-1:0] bus_o,
   output logic         bus_conflict
);
   logic [N_REG-1:0] ld_vec;
   logic [W-1:0]     reg_q   [N_REG];
   logic [W-1:0]     src_vec [N_SRC];
   logic [N_SRC-1:0] oe_vec;
   logic [W-1:0]     alu_y;
   alu_op_e          op_e;

   generate
      if (W < 1) begin : g_bad_width
         $error("bus_datapath: W must be at least 1");
      end
   endgenerate

   assign ld_vec[REG_GR1] = gr1_ld;
   assign ld_vec[REG_GR2] = gr2_ld;
   assign ld_vec[REG_DR1] = dr1_ld;
   assign ld_vec[REG_DR2] = dr2_ld;

   generate
      for (genvar r = 0; r < N_REG; r++) begin : g_reg
         dp_ldreg #(.W(W)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (ld_vec[r]),
            .d    (bus_o),
            .q    (reg_q[r])
         );
      end
   endgenerate

   assign op_e = alu_op_e'(alu_op);

   dp_alu #(.W(W)) u_alu (
      .a  (reg_q[REG_DR1]),
      .b  (reg_q[REG_DR2]),
      .op (op_e),
      .cin(alu_cin),
      .y  (alu_y)
   );

   assign src_vec[SRC_EXT] = ext_data;
   assign src_vec[SRC_GR1] = reg_q[REG_GR1];
   assign src_vec[SRC_GR2] = reg_q[REG_GR2];
   assign src_vec[SRC_ALU] = alu_y;

   assign oe_vec[SRC_EXT] = ext_oe_n;
   assign oe_vec[SRC_GR1] = gr1_oe_n;
   assign oe_vec[SRC_GR2] = gr2_oe_n;
   assign oe_vec[SRC_ALU] = alu_oe_n;

   dp_bus #(.W(W), .N(N_SRC)) u_bus (
      .oe_n    (oe_vec),
      .src     (src_vec),
      .bus     (bus_o),
      .conflict(bus_conflict)
   );
endmodule

// File: rtl/bus_datapath_chk.sv
module bus_datapath_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] ext_data,
   input logic         ext_oe_n,
   input logic         gr1_oe_n,
   input logic         gr2_oe_n,
   input logic         alu_oe_n,
   input logic         gr1_ld,
   input logic         dr1_ld,
   input logic [2:0]   alu_op,
   input logic [W-1:0] bus_o,
   input logic         bus_conflict,
   input logic [W-1:0] gr1_q,
   input logic [W-1:0] dr1_q,
   input logic [W-1:0] dr2_q
);
   logic [3:0] en_n;
   assign en_n = {alu_oe_n, gr2_oe_n, gr1_oe_n, ext_oe_n};

   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n == 4'b1111) |-> (bus_o == '0)); // R3

   AST_EXT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n == 4'b1110) |-> (bus_o == ext_data)); // R2

   AST_GR1_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n == 4'b1101) |-> (bus_o == gr1_q)); // R5

   AST_NO_FALSE_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~en_n) <= 1) |-> !bus_conflict); // R9

   AST_GR1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      gr1_ld |=> (gr1_q == $past(bus_o))); // R4

   AST_GR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !gr1_ld |=> $stable(gr1_q)); // R4

   AST_DR1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dr1_ld |=> (dr1_q == $past(bus_o))); // R6

   AST_ALU_AND_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_n == 4'b0111) && (alu_op == 3'd2)) |-> (bus_o == (dr1_q & dr2_q))); // R7
endmodule

bind bus_datapath bus_datapath_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_data    (ext_data),
   .ext_oe_n    (ext_oe_n),
   .gr1_oe_n    (gr1_oe_n),
   .gr2_oe_n    (gr2_oe_n),
   .alu_oe_n    (alu_oe_n),
   .gr1_ld      (gr1_ld),
   .dr1_ld      (dr1_ld),
   .alu_op      (alu_op),
   .bus_o       (bus_o),
   .bus_conflict(bus_conflict),
   .gr1_q       (reg_q[0]),
   .dr1_q       (reg_q[2]),
   .dr2_q       (reg_q[3])
);

// File: tb/tb_bus_datapath.sv
`timescale 1ns/100ps
module tb_bus_datapath;
   localparam int W = 8;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] ext_data = '0;
   logic         ext_oe_n = 1'b1, gr1_oe_n = 1'b1, gr2_oe_n = 1'b1, alu_oe_n = 1'b1;
   logic         gr1_ld = 1'b0, gr2_ld = 1'b0, dr1_ld = 1'b0, dr2_ld = 1'b0;
   logic [2:0]   alu_op = '0;
   logic         alu_cin = 1'b0;
   logic [W-1:0] bus_o;
   logic         bus_conflict;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural state of the reference
   int m_gr1 = 0, m_gr2 = 0, m_dr1 = 0, m_dr2 = 0;

   always #2.5 clk = ~clk;

   bus_datapath #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .ext_data(ext_data),
      .ext_oe_n(ext_oe_n), .gr1_oe_n(gr1_oe_n), .gr2_oe_n(gr2_oe_n), .alu_oe_n(alu_oe_n),
      .gr1_ld(gr1_ld), .gr2_ld(gr2_ld), .dr1_ld(dr1_ld), .dr2_ld(dr2_ld),
      .alu_op(alu_op), .alu_cin(alu_cin), .bus_o(bus_o), .bus_conflict(bus_conflict)
   );

   function automatic int ref_alu(int a, int b, int op, int cin);
      case (op)
         0: return (a + b + cin) & MASK;
         1: return (a + ((~b) & MASK) + cin) & MASK;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return (~a) & MASK;
         6: return (~b) & MASK;
         default: return a;
      endcase
   endfunction

   function automatic int ref_bus();
      int v = 0;
      if (!ext_oe_n) v |= int'(ext_data);
      if (!gr1_oe_n) v |= m_gr1;
      if (!gr2_oe_n) v |= m_gr2;
      if (!alu_oe_n) v |= ref_alu(m_dr1, m_dr2, int'(alu_op), int'(alu_cin));
      return v;
   endfunction

   function automatic int ref_active();
      return int'(!ext_oe_n) + int'(!gr1_oe_n) + int'(!gr2_oe_n) + int'(!alu_oe_n);
   endfunction

   task automatic idle();
      ext_oe_n = 1; gr1_oe_n = 1; gr2_oe_n = 1; alu_oe_n = 1;
      gr1_ld = 0; gr2_ld = 0; dr1_ld = 0; dr2_ld = 0;
   endtask

   // one bus cycle: compare at the falling edge, then advance the model at the rising edge
   task automatic cyc(string tag);
      int eb, ec;
      @(negedge clk);
      eb = ref_bus();
      ec = (ref_active() > 1) ? 1 : 0;
      checks++;
      if (int'(bus_o) != eb) begin
         errors++;
         $display("FAIL %s bus actual=%0h expected=%0h", tag, bus_o, eb);
      end
      checks++;
      if (int'(bus_conflict) != ec) begin
         errors++;
         $display("FAIL R9 conflict actual=%0d expected=%0d (%s)", bus_conflict, ec, tag);
      end
      @(posedge clk);
      if (rst_n) begin
         if (gr1_ld) m_gr1 = eb;
         if (gr2_ld) m_gr2 = eb;
         if (dr1_ld) m_dr1 = eb;
         if (dr2_ld) m_dr2 = eb;
      end
      #1;
      idle();
   endtask

   task automatic put_ext(int v, bit to_gr2);
      ext_data = W'(v); ext_oe_n = 0;
      if (to_gr2) gr2_ld = 1; else gr1_ld = 1;
      cyc("R2");
   endtask

   // R10: GR1 -> DR1, GR2 -> DR2, ALU -> destination, then show destination
   task automatic op_seq(int op, bit cin, bit dest_gr2);
      gr1_oe_n = 0; dr1_ld = 1; cyc("R10");
      gr2_oe_n = 0; dr2_ld = 1; cyc("R10");
      alu_op = 3'(op); alu_cin = cin; alu_oe_n = 0;
      if (dest_gr2) gr2_ld = 1; else gr1_ld = 1;
      cyc("R7");
      if (dest_gr2) gr2_oe_n = 0; else gr1_oe_n = 0;
      cyc("R10");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      idle();
      #1;
      gr1_oe_n = 0; cyc("R1");
      gr2_oe_n = 0; cyc("R1");
      rst_n = 1;
      #1;
      gr1_oe_n = 0; cyc("R1");
      cyc("R3");                                 // R3 idle bus
      put_ext(8'h5A, 0);                         // R2 / R4 load GR1
      put_ext(8'hC3, 1);                         // R2 / R4 load GR2
      gr1_oe_n = 0; cyc("R5");                   // R5
      gr2_oe_n = 0; cyc("R5");
      ext_data = 8'hFF; cyc("R4");               // R4 hold: no loads, no enables
      gr1_oe_n = 0; cyc("R4");
      // R6: working registers load but stay off the bus
      gr1_oe_n = 0; dr1_ld = 1; cyc("R6");
      gr2_oe_n = 0; dr2_ld = 1; cyc("R6");
      cyc("R6");
      // R8: ALU result hidden unless enabled
      alu_op = 3'd3; cyc("R8");
      alu_op = 3'd3; alu_oe_n = 0; cyc("R8");
      // R7 / R10: every code through the full sequence
      for (int op = 0; op < 8; op++) begin
         op_seq(op, 1'b0, op[0]);
         op_seq(op, 1'b1, !op[0]);
      end
      put_ext(8'hFF, 0);
      put_ext(8'h01, 1);
      op_seq(0, 1'b1, 0);                        // carry wrap FF+01+1
      op_seq(1, 1'b1, 1);                        // subtraction
      // R9: double enables OR together and a load captures the OR
      ext_data = 8'h30; ext_oe_n = 0; gr1_oe_n = 0; gr2_ld = 1; cyc("R9");
      gr2_oe_n = 0; cyc("R9");
      ext_data = 8'h0F; ext_oe_n = 0; gr1_oe_n = 0; gr2_oe_n = 0; alu_oe_n = 0; cyc("R9");
      // R1: reset in the middle clears everything
      rst_n = 0; #1;
      cyc("R1");
      m_gr1 = 0; m_gr2 = 0; m_dr1 = 0; m_dr2 = 0;
      rst_n = 1; #1;
      gr1_oe_n = 0; cyc("R1");
      alu_op = 3'd5; alu_oe_n = 0; cyc("R1");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule